// File: doc/BRIEF.md
# Serial ADC Conversion Host Controller

This block is the host side of a link to a 10-bit successive-approximation converter that is read over three wires: an active-low convert-start strobe, a serial clock and a serial data line. On a start request the controller pulls the strobe low, which begins a conversion. It then runs the serial clock, a parameterised division of the system clock, for exactly one frame and shifts in the data line. Each frame holds three leading zeros, ten data bits with the MSB first and then two sub-bits. The 10-bit result and the sub-bits are then published together with a one-cycle done pulse.

The point in the frame at which the strobe is released selects how the converter behaves. A release late in the frame (after the 15th rising serial-clock edge) is a normal conversion. In continuous mode that release lets a new conversion begin right after the frame, with no new request. A release early in the frame (after the 8th rising edge by default) puts the converter into partial power-down. A separate wake frame holds the strobe low for more than fourteen serial-clock cycles to bring it back. The first conversion after reset only calibrates the converter, so its result comes out marked by a flag. The two power-down frames publish nothing.

Top module: `adc_conv_host`

## Requirements
- R1: After reset and whenever no frame is running, the serial clock output and the convert-start output are both high and done is low.
- R2: A start request while idle drives convert-start low and runs exactly 16 rising serial-clock edges. The serial clock goes low first, and each of its low phases lasts DIV_HALF system cycles.
- R3: The data line is sampled on rising serial-clock edges 5 through 16. Edges 5 to 14 give result bits 9 down to 0, and edges 15 and 16 give sub bits 1 and 0.
- R4: A conversion frame ends with done high for exactly one system cycle. The result and sub outputs change only together with done and hold their value until the next done.
- R5: In the mode codes 0 (single), 1 (continuous) and 3 (power-down exit), convert-start rises together with the 15th rising serial-clock edge.
- R6: In mode code 2 (power-down entry), convert-start rises together with rising edge REL_PD_EDGE, default 8, which lies between the 4th and the 13th. Frames in modes 2 and 3 produce no done pulse.
- R7: In mode 1 the next frame starts right after each frame, with no new request, as long as the mode input still reads 1 at the end of the frame. Otherwise the controller returns to idle.
- R8: The calibration flag is high on the first done after reset and low on every later done. Power-down frames do not use up the calibration.
- R9: A start request that arrives while a frame is running is ignored. It changes neither the running frame's mode nor the number of frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin a frame; only taken when idle |
| mode_i | input | 2 | 0 single, 1 continuous, 2 power-down entry, 3 power-down exit |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| cnvst_n_o | output | 1 | Active-low convert-start strobe, idles high |
| done_o | output | 1 | One-cycle pulse when a new result is published |
| result_o | output | DATA_W | 10-bit conversion result |
| sub_o | output | SUB_W | Two trailing sub-bits |
| calib_o | output | 1 | Marks the published result as the calibration frame |

## Verification
The single-shot path is swept over every 10-bit result value, and the sub-bits are derived from the value's low bits. This sweep separates bit-order and off-by-one sampling faults at each position of the frame, because a misplaced sample edge shifts every word in a way the expected value catches. The power-down entry and exit frames are run before the first conversion. The point at which the strobe is released tells an early release from a late one, and those frames show that neither publishes a result nor uses up the calibration flag. A continuous run with changing words checks the order of results and the chaining from frame to frame, and that the chain stops when the mode changes. A request injected mid-frame shows that the running frame and the frame count stay untouched.

// File: rtl/adc_host_pkg.sv
// Shared types for the serial ADC host controller.
// Assumes mode codes are fixed by the user interface (see brief).
package adc_host_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_CONT     = 2'd1,
        MODE_PD_ENTER = 2'd2,
        MODE_PD_EXIT  = 2'd3
    } adc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_CLOCK = 2'd2,
        ST_END   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial-clock pacing: emits a one-cycle tick every DIV_HALF system cycles
// while run_i is high; the count restarts whenever run_i drops.
// Assumes DIV_HALF >= 1.
module adc_sclk_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    // Half-period counter, held at zero while the frame is not clocking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    generate
        if (DIV_HALF > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end
    endgenerate

endmodule

// File: rtl/adc_frame_seq.sv
// Frame sequencer: owns the convert-start strobe and the serial clock,
// counts rising serial-clock edges, marks sample points and frame end,
// and tracks the pending calibration conversion.
// Assumes tick_i paces half periods and the converter follows the
// lead-zero / MSB-first / sub-bit frame described in the brief.
module adc_frame_seq
    import adc_host_pkg::*;
#(
    parameter int LEAD_ZEROS  = 3,
    parameter int NSAMP       = 12,
    parameter int REL_PD_EDGE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req_i,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    output logic       run_o,
    output logic       sclk_o,
    output logic       cnvst_n_o,
    output logic       sample_o,
    output logic       publish_o,
    output logic       calib_o
);
    localparam int FRAME_EDGES  = LEAD_ZEROS + 1 + NSAMP;
    localparam int FIRST_SAMPLE = LEAD_ZEROS + 2;
    localparam int REL_CONV     = FRAME_EDGES - 1;
    localparam int EW           = $clog2(FRAME_EDGES + 1);

    seq_state_e    state_q;
    adc_mode_e     mode_q;
    logic [EW-1:0] edge_q;
    logic [EW-1:0] edge_nx;
    logic [EW-1:0] rel_edge;
    logic          sclk_q;
    logic          cnvst_q;
    logic          cal_pend_q;
    logic          rise;
    logic          conv_mode;

    // Derived strobes for the current half-period tick.
    always_comb begin
        edge_nx   = edge_q + 1'b1;
        rise      = (state_q == ST_CLOCK) && tick_i && !sclk_q;
        rel_edge  = (mode_q == MODE_PD_ENTER) ? EW'(REL_PD_EDGE) : EW'(REL_CONV);
        conv_mode = (mode_q == MODE_SINGLE) || (mode_q == MODE_CONT);
    end

    assign run_o     = (state_q == ST_SETUP) || (state_q == ST_CLOCK);
    assign sample_o  = rise && (edge_nx >= EW'(FIRST_SAMPLE));
    assign publish_o = (state_q == ST_END) && conv_mode;
    assign sclk_o    = sclk_q;
    assign cnvst_n_o = cnvst_q;
    assign calib_o   = cal_pend_q;

    // Frame state machine: strobe, serial clock and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_SINGLE;
            edge_q  <= '0;
            sclk_q  <= 1'b1;
            cnvst_q <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_req_i) begin
                        mode_q  <= adc_mode_e'(mode_i);
                        cnvst_q <= 1'b0;
                        edge_q  <= '0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick_i) begin
                        sclk_q  <= 1'b0;
                        state_q <= ST_CLOCK;
                    end
                end
                ST_CLOCK: begin
                    if (tick_i) begin
                        sclk_q <= ~sclk_q;
                        if (!sclk_q) begin
                            edge_q <= edge_nx;
                            if (edge_nx == rel_edge) cnvst_q <= 1'b1;
                            if (edge_nx == EW'(FRAME_EDGES)) state_q <= ST_END;
                        end
                    end
                end
                ST_END: begin
                    if (mode_q == MODE_CONT && mode_i == 2'(MODE_CONT)) begin
                        cnvst_q <= 1'b0;
                        edge_q  <= '0;
                        state_q <= ST_SETUP;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Calibration tracking: cleared by the first published conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_pend_q <= 1'b1;
        end else if (publish_o) begin
            cal_pend_q <= 1'b0;
        end
    end

    // Checker-only count of sample points within the current frame.
    logic [EW-1:0] samp_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_SETUP) begin
            samp_cnt_q <= '0;
        end else if (sample_o) begin
            samp_cnt_q <= samp_cnt_q + 1'b1;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sclk_q && cnvst_q)); // R1
    AST_SAMPLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |-> (samp_cnt_q == EW'(NSAMP))); // R3
    AST_CONV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnvst_q) && mode_q != MODE_PD_ENTER) |->
        (edge_q >= EW'(FRAME_EDGES - 2) && edge_q <= EW'(FRAME_EDGES))); // R5
    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnvst_q) && mode_q == MODE_PD_ENTER) |->
        (edge_q >= EW'(LEAD_ZEROS + 1) && edge_q < EW'(FRAME_EDGES - 2))); // R6
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOCK && start_req_i) |=> $stable(mode_q)); // R9

endmodule

// File: rtl/adc_shift_capture.sv
// Capture path: shifts the serial data in at each sample point and
// publishes the word, sub-bits and calibration flag with a done pulse.
// Assumes exactly NSAMP sample points precede each publish.
module adc_shift_capture #(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              sdata_i,
    input  logic              publish_i,
    input  logic              calib_i,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [SUB_W-1:0]  sub_o,
    output logic              calib_o
);
    localparam int NSAMP = DATA_W + SUB_W;

    logic [NSAMP-1:0] shreg_q;
    logic             seen_done_q;

    // Serial-in shift register, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (sample_i) begin
            shreg_q <= {shreg_q[NSAMP-2:0], sdata_i};
        end
    end

    // Output registers, updated only on publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
            sub_o    <= '0;
            calib_o  <= 1'b0;
        end else begin
            done_o <= publish_i;
            if (publish_i) begin
                result_o <= shreg_q[NSAMP-1:SUB_W];
                sub_o    <= shreg_q[SUB_W-1:0];
                calib_o  <= calib_i;
            end
        end
    end

    // Checker-only record of a previous done since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_done_q <= 1'b0;
        end else if (done_o) begin
            seen_done_q <= 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o) && $stable(sub_o)); // R4
    AST_CALIB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && seen_done_q) |-> !calib_o); // R8

endmodule

// File: rtl/adc_conv_host.sv
// Top of the serial ADC host controller: ties the serial-clock pacer,
// the frame sequencer and the capture path together.
// Assumes sdata_i is synchronous to clk (converter clocked by sclk_o).
module adc_conv_host #(
    parameter int DIV_HALF    = 4,
    parameter int DATA_W      = 10,
    parameter int SUB_W       = 2,
    parameter int LEAD_ZEROS  = 3,
    parameter int REL_PD_EDGE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [1:0]        mode_i,
    input  logic              sdata_i,
    output logic              sclk_o,
    output logic              cnvst_n_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [SUB_W-1:0]  sub_o,
    output logic              calib_o
);
    localparam int NSAMP = DATA_W + SUB_W;

    logic run;
    logic tick;
    logic sample;
    logic publish;
    logic cal_pend;

    adc_sclk_gen #(
        .DIV_HALF (DIV_HALF)
    ) i_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    adc_frame_seq #(
        .LEAD_ZEROS  (LEAD_ZEROS),
        .NSAMP       (NSAMP),
        .REL_PD_EDGE (REL_PD_EDGE)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .mode_i      (mode_i),
        .tick_i      (tick),
        .run_o       (run),
        .sclk_o      (sclk_o),
        .cnvst_n_o   (cnvst_n_o),
        .sample_o    (sample),
        .publish_o   (publish),
        .calib_o     (cal_pend)
    );

    adc_shift_capture #(
        .DATA_W (DATA_W),
        .SUB_W  (SUB_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample),
        .sdata_i   (sdata_i),
        .publish_i (publish),
        .calib_i   (cal_pend),
        .done_o    (done_o),
        .result_o  (result_o),
        .sub_o     (sub_o),
        .calib_o   (calib_o)
    );

endmodule

// File: tb/test_adc_conv_host.sv
// Bench: behavioural converter model plus sweeps of every result value,
// power-down framing, continuous chaining and ignored requests.
module test_adc_conv_host;

    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        sdata = 1'b0;
    logic        sclk;
    logic        cnvst_n;
    logic        done;
    logic [9:0]  result;
    logic [1:0]  sub;
    logic        calib;

    always #5 clk = ~clk;

    adc_conv_host #(.DIV_HALF(DIV)) i_adc_conv_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .mode_i    (mode),
        .sdata_i   (sdata),
        .sclk_o    (sclk),
        .cnvst_n_o (cnvst_n),
        .done_o    (done),
        .result_o  (result),
        .sub_o     (sub),
        .calib_o   (calib)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: frame word presented bit by bit after rising edges 4..15.
    int         edge_n = 0;
    int         frames = 0;
    int         rel_edge = -1;
    logic [11:0] cur_word = '0;
    logic [11:0] next_word = '0;

    always @(negedge cnvst_n) begin
        edge_n   = 0;
        cur_word = next_word;
        next_word = next_word + 12'h155;
        frames++;
        sdata <= #2 1'b0;
    end

    always @(posedge sclk) begin
        edge_n++;
        if (edge_n >= 4 && edge_n <= 15) sdata <= #2 cur_word[15 - edge_n];
        else sdata <= #2 1'b0;
    end

    always @(posedge cnvst_n) begin
        #1;
        rel_edge = edge_n;
    end

    // Output monitor, sampled away from the active edge.
    int          done_cnt = 0;
    logic [11:0] done_words [0:15];
    logic        last_cal = 1'b0;
    int          low_run = 0;
    int          last_low = 0;
    int          cycles = 0;

    always @(negedge clk) begin
        cycles++;
        if (done) begin
            done_words[done_cnt & 15] = {result, sub};
            last_cal = calib;
            done_cnt++;
        end
        if (rst_n && !sclk) low_run++;
        else if (low_run > 0) begin
            last_low = low_run;
            low_run = 0;
        end
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic start_frame(input logic [1:0] m, input logic [11:0] w);
        @(negedge clk);
        next_word = w;
        mode = m;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_frame();
        for (int t = 0; t < 400 && edge_n < 16; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int d0;
        int f0;
        logic [11:0] w;

        repeat (4) @(negedge clk);
        chk(cnvst_n === 1'b1 && sclk === 1'b1, "R1 reset levels", {sclk, cnvst_n}, 3);
        chk(done === 1'b0, "R1 reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Power-down entry before any conversion.
        d0 = done_cnt;
        start_frame(2'd2, 12'hABC);
        wait_frame();
        chk(rel_edge == 8, "R6 pd release edge", rel_edge, 8);
        chk(edge_n == 16, "R2 edges per frame", edge_n, 16);
        chk(last_low == DIV, "R2 low phase length", last_low, DIV);
        chk(done_cnt == d0, "R6 no done on pd entry", done_cnt, d0);

        // Power-down exit.
        start_frame(2'd3, 12'h123);
        wait_frame();
        chk(rel_edge == 15, "R5 wake release edge", rel_edge, 15);
        chk(done_cnt == d0, "R6 no done on pd exit", done_cnt, d0);
        chk(sclk === 1'b1 && cnvst_n === 1'b1, "R1 idle levels", {sclk, cnvst_n}, 3);

        // First conversion is the calibration one.
        start_frame(2'd0, 12'h3C5);
        wait_frame();
        chk(done_cnt == d0 + 1, "R4 one done per single", done_cnt, d0 + 1);
        chk(last_cal == 1'b1, "R8 first done flagged", last_cal, 1);
        chk(done_words[d0 & 15] == 12'h3C5, "R3 first word", done_words[d0 & 15], 12'h3C5);
        chk(rel_edge == 15, "R5 single release edge", rel_edge, 15);

        // Sweep of every result value.
        for (int i = 0; i < 1024; i++) begin
            w = {i[9:0], i[1:0] ^ 2'b10};
            d0 = done_cnt;
            start_frame(2'd0, w);
            wait_frame();
            chk(done_cnt == d0 + 1 && done_words[d0 & 15] == w, "R3 sweep word",
                done_words[d0 & 15], w);
            if (i == 0) chk(last_cal == 1'b0, "R8 later done unflagged", last_cal, 0);
            if (i == 1023) chk(edge_n == 16, "R2 edges in sweep", edge_n, 16);
        end
        repeat (40) @(negedge clk);
        chk({result, sub} == 12'hFFD, "R4 result held", {result, sub}, 12'hFFD);

        // Request during a frame is ignored.
        d0 = done_cnt;
        start_frame(2'd0, 12'h5A6);
        repeat (10) @(negedge clk);
        mode = 2'd2;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        f0 = frames;
        wait_frame();
        chk(rel_edge == 15, "R9 mode unchanged", rel_edge, 15);
        chk(done_cnt == d0 + 1 && done_words[d0 & 15] == 12'h5A6, "R9 frame intact",
            done_words[d0 & 15], 12'h5A6);
        repeat (100) @(negedge clk);
        chk(frames == f0 && cnvst_n === 1'b1, "R9 no extra frame", frames, f0);

        // Continuous chaining.
        d0 = done_cnt;
        start_frame(2'd1, 12'h100);
        for (int t = 0; t < 2000 && done_cnt < d0 + 3; t++) @(negedge clk);
        mode = 2'd0;
        repeat (300) @(negedge clk);
        chk(done_cnt - d0 == 4, "R7 chained frame count", done_cnt - d0, 4);
        for (int k = 0; k < 4; k++) begin
            w = 12'h100 + 12'(k * 12'h155);
            chk(done_words[(d0 + k) & 15] == w, "R7 chained word order",
                done_words[(d0 + k) & 15], w);
        end
        f0 = frames;
        repeat (100) @(negedge clk);
        chk(frames == f0 && cnvst_n === 1'b1 && sclk === 1'b1, "R7 stop to idle", frames, f0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule